// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Functional Model

This block is a clock-sampled functional stand-in for a 16-bit asynchronous static RAM. It is meant as the target device when verifying an SRAM controller. On every clock edge it samples five active-low controls: chip select, write strobe, output gate, and one enable for each byte lane. From these it decides whether the cycle is standby, a write, a read, or an active cycle with the outputs off. Writes are stored one byte lane at a time. Read data leaves on a separate data bus, and a per-lane drive flag stands in for the tri-state pins.

The array depth is a parameter and defaults to 256 words. Only the low address bits that index the array are decoded. The model also watches for two write-timing faults: the address moving while the write strobe is held low, and the write data changing in the last cycle of a write pulse. Either fault raises a one-cycle error flag. All outputs are registered and describe the cycle sampled at the previous edge.

Top module: `bytelane_sram_model`

## Requirements
- R1: With `cs_n` high the cycle is standby. On the next cycle `rd_drive` is 0. The array is not written, whatever the other inputs do.
- R2: With `cs_n` low and both `lane_en_n` bits high, the cycle is also standby. Nothing is written, and `rd_drive` is 0 on the next cycle.
- R3: With `cs_n` low, `we_n` low and at least one lane enabled, the cycle is a write, whatever `oe_n` is. Enabled lanes of `wdata` are stored at the decoded address at the sampling edge, and `rd_drive` is 0 on the next cycle.
- R4: With `cs_n` low, `we_n` high and `oe_n` low, the cycle is a read. On the next cycle `rdata` carries the stored word on each enabled lane, and `rd_drive` has a 1 for each enabled lane.
- R5: With `cs_n` low and both `we_n` and `oe_n` high, the cycle is active with outputs off. `rd_drive` is 0 on the next cycle, and nothing is written.
- R6: `lane_en_n[0]` governs bits 7:0 and `rd_drive[0]`. `lane_en_n[1]` governs bits 15:8 and `rd_drive[1]`. A lane that is not enabled keeps its stored byte on a write. On a read it is not driven and reads as zero on `rdata`.
- R7: Only `addr[log2(DEPTH)-1:0]` is decoded. Addresses that differ only above those bits reach the same word.
- R8: A write cycle that directly follows a write cycle at a different address sets `proto_err` high on the next cycle, for one cycle.
- R9: A write pulse is a run of consecutive write cycles. If its last cycle carries `wdata` different from the cycle before it, `proto_err` is high in the cycle after the first non-write cycle, for one cycle. A pulse with steady data raises no flag.
- R10: While `rst_n` is low, `rd_drive`, `rdata` and `proto_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the output and monitor registers |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output gate |
| lane_en_n | input | 2 | Active-low byte-lane enables; bit 0 selects the low byte |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data; zero on lanes not driven |
| rd_drive | output | 2 | Per-lane drive flag modelling the tri-state enable |
| proto_err | output | 1 | One-cycle write-timing fault flag |

## Verification
Each stimulus cycle is applied just after a rising edge and sampled at the next one, so every read result and drive flag is due one edge later. The bench checks them just after that edge.

An address fault appears on the same schedule. A data fault in the last cycle of a pulse only shows one cycle after the first non-write cycle that follows the pulse. The bench therefore checks that flag after the closing idle cycle, and checks it is still low before then. Writes that must be ignored are confirmed by reading the word back through a later read cycle.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

   typedef enum logic [1:0] {
      MD_STANDBY = 2'd0,
      MD_WRITE   = 2'd1,
      MD_READ    = 2'd2,
      MD_IDLE    = 2'd3
   } sram_mode_e;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
   import sram_model_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             cs_n,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [LANES-1:0] lane_en_n,
   output sram_mode_e       mode,
   output logic [LANES-1:0] lane_sel
);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("sram_mode_decode: LANES must be at least 1");
      end
   endgenerate

   assign lane_sel = ~lane_en_n;

   // Priority: deselect or no lane -> standby; write strobe beats output gate
   always_comb begin
      if (cs_n || (&lane_en_n))
         mode = MD_STANDBY;
      else if (!we_n)
         mode = MD_WRITE;
      else if (!oe_n)
         mode = MD_READ;
      else
         mode = MD_IDLE;
   end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
   parameter int LANE_W = 8,
   parameter int DEPTH  = 256,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [LANE_W-1:0] wd,
   output logic [LANE_W-1:0] rd,
   output logic              rd_oe
);

   generate
      if (LANE_W < 1) begin : g_bad_w
         $error("sram_lane_bank: LANE_W must be positive");
      end
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sram_lane_bank: DEPTH must be a power of two");
      end
   endgenerate

   logic [LANE_W-1:0] mem [DEPTH];

   // Storage holds no reset, as a real array would not
   always_ff @(posedge clk) begin
      if (wr_en)
         mem[idx] <= wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd    <= '0;
         rd_oe <= 1'b0;
      end else begin
         rd    <= rd_en ? mem[idx] : '0;
         rd_oe <= rd_en;
      end
   end

   // R6: an undriven lane must present zero
   a_r6_quiet_lane: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_oe |-> (rd == '0));

   // R3: a lane being written is never driven on the next cycle
   a_r3_no_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !rd_oe);

endmodule

// File: rtl/sram_write_monitor.sv
module sram_write_monitor #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cyc,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              proto_err
);

   logic              wr_q;
   logic              chg_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              past_ok;
   logic              addr_fault;
   logic              data_fault;

   // Address moved inside a pulse
   assign addr_fault = wr_cyc && wr_q && (addr != addr_q);
   // Pulse just ended and its last cycle changed the data
   assign data_fault = wr_q && !wr_cyc && chg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q      <= 1'b0;
         chg_q     <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         proto_err <= 1'b0;
         past_ok   <= 1'b0;
      end else begin
         wr_q      <= wr_cyc;
         chg_q     <= wr_cyc && wr_q && (wdata != wdata_q);
         addr_q    <= addr;
         wdata_q   <= wdata;
         proto_err <= addr_fault || data_fault;
         past_ok   <= 1'b1;
      end
   end

   // R8: address change between back-to-back write cycles raises the flag
   a_r8_addr_move: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && wr_cyc && $past(wr_cyc) && (addr != $past(addr))) |=> proto_err);

   // R8/R9: the flag never follows a cycle outside or at the start of a pulse
   a_r9_flag_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(wr_cyc)) |=> !proto_err);

endmodule

// File: rtl/bytelane_sram_model.sv
module bytelane_sram_model
   import sram_model_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   parameter int DEPTH  = 256,
   parameter int ADDR_W = 18,
   localparam int DATA_W = LANE_W * LANES,
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [LANES-1:0]  lane_en_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [LANES-1:0]  rd_drive,
   output logic              proto_err
);

   generate
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("bytelane_sram_model: ADDR_W too narrow for DEPTH");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("bytelane_sram_model: DEPTH must be at least 2");
      end
   endgenerate

   sram_mode_e       mode;
   logic [LANES-1:0] lane_sel;
   logic             wr_cyc;
   logic             rd_cyc;

   sram_mode_decode #(.LANES(LANES)) u_decode (
      .cs_n      (cs_n),
      .we_n      (we_n),
      .oe_n      (oe_n),
      .lane_en_n (lane_en_n),
      .mode      (mode),
      .lane_sel  (lane_sel)
   );

   assign wr_cyc = (mode == MD_WRITE);
   assign rd_cyc = (mode == MD_READ);

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         sram_lane_bank #(.LANE_W(LANE_W), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_cyc && lane_sel[g]),
            .rd_en (rd_cyc && lane_sel[g]),
            .idx   (addr[IDX_W-1:0]),
            .wd    (wdata[g*LANE_W +: LANE_W]),
            .rd    (rdata[g*LANE_W +: LANE_W]),
            .rd_oe (rd_drive[g])
         );
      end
   endgenerate

   sram_write_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_cyc    (wr_cyc),
      .addr      (addr),
      .wdata     (wdata),
      .proto_err (proto_err)
   );

   // R1: deselect leaves every lane undriven next cycle
   a_r1_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (rd_drive == '0));

   // R2: no lane enabled counts as standby
   a_r2_no_lane_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && (&lane_en_n)) |=> (rd_drive == '0));

   // R3: write strobe overrides the output gate
   a_r3_write_beats_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !we_n) |=> (rd_drive == '0));

   // R5: active with outputs gated off
   a_r5_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && we_n && oe_n) |=> (rd_drive == '0));

   // R4: a read drives exactly the enabled lanes
   a_r4_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && we_n && !oe_n) |=> (rd_drive == ~$past(lane_en_n)));

endmodule

// File: tb/tb_bytelane_sram_model.sv
module tb_bytelane_sram_model;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs_n, we_n, oe_n;
   logic [1:0]  lane_en_n;
   logic [17:0] addr;
   logic [15:0] wdata;
   logic [15:0] rdata;
   logic [1:0]  rd_drive;
   logic        proto_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bytelane_sram_model dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
      .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rd_drive(rd_drive), .proto_err(proto_err)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // One cycle: drive just after an edge, return just after the sampling edge
   task automatic cyc(input logic c, input logic w, input logic o,
                      input logic [1:0] ln, input logic [17:0] a,
                      input logic [15:0] d);
      cs_n = c; we_n = w; oe_n = o; lane_en_n = ln; addr = a; wdata = d;
      @(posedge clk); #1;
   endtask

   task automatic idle_gap();
      cyc(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0);
      cyc(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0);
   endtask

   task automatic read_word(input logic [17:0] a, input logic [1:0] ln,
                            input logic [15:0] exp_d, input logic [1:0] exp_oe,
                            input string req);
      cyc(1'b0, 1'b1, 1'b0, ln, a, 16'hDEAD);
      chk(rdata == exp_d, req, {16'h0, rdata}, {16'h0, exp_d});
      chk(rd_drive == exp_oe, req, {30'h0, rd_drive}, {30'h0, exp_oe});
   endtask

   task automatic t_reset();
      chk(rd_drive == 2'b00, "R10", {30'h0, rd_drive}, 32'h0);
      chk(rdata == 16'h0, "R10", {16'h0, rdata}, 32'h0);
      chk(proto_err == 1'b0, "R10", {31'h0, proto_err}, 32'h0);
   endtask

   task automatic t_write_read();
      // R3: oe_n low during the write must not matter
      cyc(1'b0, 1'b0, 1'b0, 2'b00, 18'd5, 16'hA5C3);
      chk(rd_drive == 2'b00, "R3", {30'h0, rd_drive}, 32'h0);
      cyc(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0);
      read_word(18'd5, 2'b00, 16'hA5C3, 2'b11, "R4");
      idle_gap();
   endtask

   task automatic t_standby();
      cyc(1'b1, 1'b0, 1'b0, 2'b00, 18'd5, 16'h1111);
      chk(rd_drive == 2'b00, "R1", {30'h0, rd_drive}, 32'h0);
      cyc(1'b1, 1'b1, 1'b0, 2'b00, 18'd5, 16'h0);
      chk(rd_drive == 2'b00, "R1", {30'h0, rd_drive}, 32'h0);
      read_word(18'd5, 2'b00, 16'hA5C3, 2'b11, "R1");
      idle_gap();
      cyc(1'b0, 1'b0, 1'b1, 2'b11, 18'd5, 16'h2222);
      chk(rd_drive == 2'b00, "R2", {30'h0, rd_drive}, 32'h0);
      cyc(1'b0, 1'b1, 1'b0, 2'b11, 18'd5, 16'h0);
      chk(rd_drive == 2'b00, "R2", {30'h0, rd_drive}, 32'h0);
      read_word(18'd5, 2'b00, 16'hA5C3, 2'b11, "R2");
      idle_gap();
      cyc(1'b0, 1'b1, 1'b1, 2'b00, 18'd5, 16'h3333);
      chk(rd_drive == 2'b00, "R5", {30'h0, rd_drive}, 32'h0);
      read_word(18'd5, 2'b00, 16'hA5C3, 2'b11, "R5");
      idle_gap();
   endtask

   task automatic t_lanes();
      // Only the low lane written: word becomes 0xA588
      cyc(1'b0, 1'b0, 1'b1, 2'b10, 18'd5, 16'h7788);
      cyc(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0);
      read_word(18'd5, 2'b10, 16'h0088, 2'b01, "R6");
      read_word(18'd5, 2'b01, 16'hA500, 2'b10, "R6");
      read_word(18'd5, 2'b00, 16'hA588, 2'b11, "R6");
      idle_gap();
   endtask

   task automatic t_alias();
      cyc(1'b0, 1'b0, 1'b1, 2'b00, 18'd259, 16'h3C3C);
      cyc(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0);
      read_word(18'd3, 2'b00, 16'h3C3C, 2'b11, "R7");
      idle_gap();
   endtask

   task automatic t_addr_fault();
      cyc(1'b0, 1'b0, 1'b1, 2'b00, 18'd10, 16'h0101);
      chk(proto_err == 1'b0, "R8", {31'h0, proto_err}, 32'h0);
      cyc(1'b0, 1'b0, 1'b1, 2'b00, 18'd11, 16'h0101);
      chk(proto_err == 1'b1, "R8", {31'h0, proto_err}, 32'h1);
      cyc(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0);
      chk(proto_err == 1'b0, "R8", {31'h0, proto_err}, 32'h0);
      idle_gap();
   endtask

   task automatic t_data_fault();
      cyc(1'b0, 1'b0, 1'b1, 2'b00, 18'd20, 16'h0001);
      cyc(1'b0, 1'b0, 1'b1, 2'b00, 18'd20, 16'h0002);
      chk(proto_err == 1'b0, "R9", {31'h0, proto_err}, 32'h0);
      cyc(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0);
      chk(proto_err == 1'b1, "R9", {31'h0, proto_err}, 32'h1);
      cyc(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0);
      chk(proto_err == 1'b0, "R9", {31'h0, proto_err}, 32'h0);
      // Steady pulse: no flag
      cyc(1'b0, 1'b0, 1'b1, 2'b00, 18'd30, 16'h4242);
      cyc(1'b0, 1'b0, 1'b1, 2'b00, 18'd30, 16'h4242);
      cyc(1'b1, 1'b1, 1'b1, 2'b11, 18'd0, 16'h0);
      chk(proto_err == 1'b0, "R9", {31'h0, proto_err}, 32'h0);
      read_word(18'd30, 2'b00, 16'h4242, 2'b11, "R3");
      idle_gap();
   endtask

   initial begin
      rst_n = 1'b0;
      cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lane_en_n = 2'b11;
      addr = '0; wdata = '0;
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_write_read();
      t_standby();
      t_lanes();
      t_alias();
      t_addr_fault();
      t_data_fault();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule